// File: doc/BRIEF.md
# Invalidation Completion Interrupt Controller

This block decides when to send a message-signalled interrupt for wait descriptors that complete in an IOMMU invalidation queue. The queue engine pulses `cpl_valid_i` when a wait descriptor completes and uses `cpl_if_i` to say whether that descriptor asked for an interrupt. Such a completion sets a sticky completion-status flag. If that flag was clear before the completion, the completion also arms a pending flag. The pending flag stays armed until the interrupt message leaves, or until software clears the completion status.

A 32-bit control word holds the software mask and the pending flag. The message payload and the target address sit in their own registers. A simple register port reads and writes all of them. The message request is raised only while the block is pending, unmasked and the message fabric is not busy. A capability input says whether queued invalidation is supported. When it is low, the control word reads as zero, ignores writes, and the block raises no messages.

Top module: `inv_cpl_irq_ctrl`

## Requirements
- R1: After reset the control word (offset 0x00) reads 0x8000_0000, the status word (offset 0x04) reads 0, `rd_data_o` is 0 and `msg_req_o` is low.
- R2: Control bit 31 is the mask: it can be read and written. Control bit 30 is the pending flag: software cannot write it. Control bits 29:0 always read 0.
- R3: A cycle with `cpl_valid_i` and `cpl_if_i` both high sets status bit 0 at the next edge. A completion with `cpl_if_i` low changes nothing.
- R4: A qualifying completion arms pending only if status bit 0 was clear before it (or is being cleared in the same cycle, see R8). A completion that finds the status already set leaves pending unchanged.
- R5: `msg_req_o` is high in exactly the cycles where pending is 1, the mask is 0, `fabric_busy_i` is 0 and `qinv_supported_i` is 1. It never rises while the mask is 1.
- R6: Pending holds while the message is blocked by the mask or by `fabric_busy_i`. It clears at the edge that ends a cycle with `msg_req_o` high.
- R7: Writing 1 to status bit 0 clears the status flag and the pending flag at the next edge, whether or not a message was sent. Writing 0 to that bit leaves both unchanged.
- R8: If a status clear and a qualifying completion arrive in the same cycle, the completion wins: the status stays 1 and pending is armed.
- R9: The message payload register (offset 0x08) drives `msg_data_o`. The address registers (low half at offset 0x0C, high half at offset 0x10) drive `msg_addr_o`. All three read back what was written.
- R10: While `qinv_supported_i` is 0, the control word reads 0 and writes to it are ignored, pending is forced to 0, and `msg_req_o` stays low.
- R11: `rd_data_o` loads at the edge that ends a cycle with `rd_en_i` high, and holds otherwise. Offsets outside the five registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| qinv_supported_i | input | 1 | Queued invalidation capability present |
| cpl_valid_i | input | 1 | One-cycle pulse: wait descriptor completed |
| cpl_if_i | input | 1 | The completed descriptor requested an interrupt |
| fabric_busy_i | input | 1 | Message fabric cannot take a message this cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write byte offset |
| wr_data_i | input | 32 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W | Register read byte offset |
| rd_data_o | output | 32 | Registered read data |
| msg_req_o | output | 1 | Interrupt message issued this cycle |
| msg_data_o | output | 32 | Message payload |
| msg_addr_o | output | MSG_ADDR_W | Message target address |

## Verification
`msg_req_o` is combinational: it follows the current pending, mask, busy and capability state in the same cycle. Completions, writes and issued messages update the flags at the next rising edge. A read loads `rd_data_o` at the rising edge that ends its strobe cycle, so a read issued in the cycle after a completion already sees the new pending bit. The bench drives inputs just after the falling edge and compares `msg_req_o`, `msg_data_o` and `msg_addr_o` against its model 1 ns later. It compares `rd_data_o` 1 ns after the rising edge. Its model advances at that same edge, so each expected value is taken from the state that the design holds at that moment.

// File: rtl/inv_irq_pkg.sv
// Shared constants and types of the invalidation completion interrupt controller.
// Assumes byte offsets into a 32-bit register window; offsets fit any ADDR_W >= 5.
package inv_irq_pkg;

    localparam int REG_W          = 32;
    localparam int OFS_CTRL       = 'h00;
    localparam int OFS_STAT       = 'h04;
    localparam int OFS_MDATA      = 'h08;
    localparam int OFS_MADDR_LO   = 'h0C;
    localparam int OFS_MADDR_HI   = 'h10;

    localparam int CTRL_MASK_BIT  = 31;
    localparam int CTRL_PEND_BIT  = 30;
    localparam int STAT_CPL_BIT   = 0;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_MDATA,
        SEL_MADDR_LO,
        SEL_MADDR_HI
    } reg_sel_e;

endpackage

// File: rtl/irq_addr_dec.sv
// Register offset decoder.
// Maps a byte offset onto one register select; unknown offsets give SEL_NONE.
// Assumes ADDR_W is wide enough to hold the highest register offset.
module irq_addr_dec
    import inv_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);

    // Purely combinational offset compare.
    always_comb begin
        case (addr_i)
            ADDR_W'(OFS_CTRL):     sel_o = SEL_CTRL;
            ADDR_W'(OFS_STAT):     sel_o = SEL_STAT;
            ADDR_W'(OFS_MDATA):    sel_o = SEL_MDATA;
            ADDR_W'(OFS_MADDR_LO): sel_o = SEL_MADDR_LO;
            ADDR_W'(OFS_MADDR_HI): sel_o = SEL_MADDR_HI;
            default:               sel_o = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/irq_cfg_regs.sv
// Software-owned configuration: the interrupt mask and the message payload and address.
// The mask resets to 1 (masked). Mask writes are dropped while the capability is absent.
// The upper address register keeps only MSG_ADDR_W-32 bits; 33 <= MSG_ADDR_W <= 64.
module irq_cfg_regs
    import inv_irq_pkg::*;
#(
    parameter int MSG_ADDR_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  qinv_ok_i,
    input  logic                  wr_en_i,
    input  reg_sel_e              wr_sel_i,
    input  logic [REG_W-1:0]      wr_data_i,
    output logic                  mask_o,
    output logic [REG_W-1:0]      mdata_o,
    output logic [REG_W-1:0]      maddr_lo_o,
    output logic [REG_W-1:0]      maddr_hi_o,
    output logic [MSG_ADDR_W-1:0] msg_addr_o
);

    localparam int               HI_W    = MSG_ADDR_W - REG_W;
    localparam logic [REG_W-1:0] HI_KEEP = 32'hFFFF_FFFF >> (2 * REG_W - MSG_ADDR_W);

    logic             mask_q;
    logic [REG_W-1:0] mdata_q;
    logic [REG_W-1:0] lo_q;
    logic [REG_W-1:0] hi_q;

    // Mask bit: reset to masked, written only when the capability is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b1;
        end else if (wr_en_i && wr_sel_i == SEL_CTRL && qinv_ok_i) begin
            mask_q <= wr_data_i[CTRL_MASK_BIT];
        end
    end

    // Message payload and address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdata_q <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
        end else if (wr_en_i) begin
            case (wr_sel_i)
                SEL_MDATA:    mdata_q <= wr_data_i;
                SEL_MADDR_LO: lo_q    <= wr_data_i;
                SEL_MADDR_HI: hi_q    <= wr_data_i & HI_KEEP;
                default:      ;
            endcase
        end
    end

    assign mask_o     = mask_q;
    assign mdata_o    = mdata_q;
    assign maddr_lo_o = lo_q;
    assign maddr_hi_o = hi_q;
    assign msg_addr_o = {hi_q[HI_W-1:0], lo_q};

endmodule

// File: rtl/irq_pend_ctrl.sv
// Completion status and interrupt pending state, plus the message request.
// Only a clear-to-set change of the status arms pending. A write-1 clear that lands in
// the same cycle as a new completion loses to it. Pending clears when a message leaves
// or when software clears the status. Assumes cpl_valid_i is a one-cycle pulse per completion.
module irq_pend_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic qinv_ok_i,
    input  logic cpl_valid_i,
    input  logic cpl_if_i,
    input  logic stat_w1c_i,
    input  logic mask_i,
    input  logic busy_i,
    output logic stat_o,
    output logic pend_o,
    output logic msg_req_o
);

    logic stat_q;
    logic pend_q;
    logic qual_cpl;
    logic new_cond;
    logic send;

    // Qualifying completion, and whether it forms a new interrupt condition.
    always_comb begin
        qual_cpl = cpl_valid_i && cpl_if_i;
        new_cond = qual_cpl && (!stat_q || stat_w1c_i) && qinv_ok_i;
        send     = qinv_ok_i && pend_q && !mask_i && !busy_i;
    end

    // Sticky completion status: set by a completion, cleared by a software write of 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
        end else if (qual_cpl) begin
            stat_q <= 1'b1;
        end else if (stat_w1c_i) begin
            stat_q <= 1'b0;
        end
    end

    // Pending flag: armed by a new condition, dropped on send, on a status clear or when unsupported.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (!qinv_ok_i) begin
            pend_q <= 1'b0;
        end else if (new_cond) begin
            pend_q <= 1'b1;
        end else if (send || stat_w1c_i) begin
            pend_q <= 1'b0;
        end
    end

    assign stat_o    = stat_q;
    assign pend_o    = pend_q;
    assign msg_req_o = send;

endmodule

// File: rtl/irq_rd_mux.sv
// Registered read port over all registers of the controller.
// The control word reads zero when the capability is absent. Unknown offsets read zero.
module irq_rd_mux
    import inv_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en_i,
    input  reg_sel_e         rd_sel_i,
    input  logic             qinv_ok_i,
    input  logic             mask_i,
    input  logic             pend_i,
    input  logic             stat_i,
    input  logic [REG_W-1:0] mdata_i,
    input  logic [REG_W-1:0] maddr_lo_i,
    input  logic [REG_W-1:0] maddr_hi_i,
    output logic [REG_W-1:0] rd_data_o
);

    logic [REG_W-1:0] ctrl_word;
    logic [REG_W-1:0] stat_word;
    logic [REG_W-1:0] rd_next;

    // Assemble the control and status words from their single-bit fields.
    always_comb begin
        ctrl_word = '0;
        stat_word = '0;
        if (qinv_ok_i) begin
            ctrl_word[CTRL_MASK_BIT] = mask_i;
            ctrl_word[CTRL_PEND_BIT] = pend_i;
        end
        stat_word[STAT_CPL_BIT] = stat_i;
    end

    // Select the addressed word.
    always_comb begin
        case (rd_sel_i)
            SEL_CTRL:     rd_next = ctrl_word;
            SEL_STAT:     rd_next = stat_word;
            SEL_MDATA:    rd_next = mdata_i;
            SEL_MADDR_LO: rd_next = maddr_lo_i;
            SEL_MADDR_HI: rd_next = maddr_hi_i;
            default:      rd_next = '0;
        endcase
    end

    // Capture read data on a read strobe; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o <= '0;
        end else if (rd_en_i) begin
            rd_data_o <= rd_next;
        end
    end

endmodule

// File: rtl/inv_cpl_irq_ctrl.sv
// Invalidation completion interrupt controller (top).
// Ties address decode, configuration registers, pending control and the read port together.
// Assumes 33 <= MSG_ADDR_W <= 64 and ADDR_W >= 5.
module inv_cpl_irq_ctrl
    import inv_irq_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int MSG_ADDR_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  qinv_supported_i,
    input  logic                  cpl_valid_i,
    input  logic                  cpl_if_i,
    input  logic                  fabric_busy_i,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     wr_addr_i,
    input  logic [REG_W-1:0]      wr_data_i,
    input  logic                  rd_en_i,
    input  logic [ADDR_W-1:0]     rd_addr_i,
    output logic [REG_W-1:0]      rd_data_o,
    output logic                  msg_req_o,
    output logic [REG_W-1:0]      msg_data_o,
    output logic [MSG_ADDR_W-1:0] msg_addr_o
);

    reg_sel_e         wr_sel;
    reg_sel_e         rd_sel;
    logic             mask_w;
    logic             stat_w;
    logic             pend_w;
    logic             stat_w1c;
    logic [REG_W-1:0] maddr_lo_w;
    logic [REG_W-1:0] maddr_hi_w;

    irq_addr_dec #(.ADDR_W(ADDR_W)) wr_dec_i (
        .addr_i (wr_addr_i),
        .sel_o  (wr_sel)
    );

    irq_addr_dec #(.ADDR_W(ADDR_W)) rd_dec_i (
        .addr_i (rd_addr_i),
        .sel_o  (rd_sel)
    );

    // Software write of 1 to the completion status bit.
    assign stat_w1c = wr_en_i && (wr_sel == SEL_STAT) && wr_data_i[STAT_CPL_BIT];

    irq_cfg_regs #(.MSG_ADDR_W(MSG_ADDR_W)) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .qinv_ok_i  (qinv_supported_i),
        .wr_en_i    (wr_en_i),
        .wr_sel_i   (wr_sel),
        .wr_data_i  (wr_data_i),
        .mask_o     (mask_w),
        .mdata_o    (msg_data_o),
        .maddr_lo_o (maddr_lo_w),
        .maddr_hi_o (maddr_hi_w),
        .msg_addr_o (msg_addr_o)
    );

    irq_pend_ctrl pend_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .qinv_ok_i   (qinv_supported_i),
        .cpl_valid_i (cpl_valid_i),
        .cpl_if_i    (cpl_if_i),
        .stat_w1c_i  (stat_w1c),
        .mask_i      (mask_w),
        .busy_i      (fabric_busy_i),
        .stat_o      (stat_w),
        .pend_o      (pend_w),
        .msg_req_o   (msg_req_o)
    );

    irq_rd_mux rd_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en_i    (rd_en_i),
        .rd_sel_i   (rd_sel),
        .qinv_ok_i  (qinv_supported_i),
        .mask_i     (mask_w),
        .pend_i     (pend_w),
        .stat_i     (stat_w),
        .mdata_i    (msg_data_o),
        .maddr_lo_i (maddr_lo_w),
        .maddr_hi_i (maddr_hi_w),
        .rd_data_o  (rd_data_o)
    );

endmodule

// File: rtl/inv_cpl_irq_ctrl_chk.sv
// Property checker for inv_cpl_irq_ctrl, attached by bind below.
// Watches the ports together with the internal mask, status and pending flags.
module inv_cpl_irq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic qinv_supported_i,
    input logic cpl_valid_i,
    input logic cpl_if_i,
    input logic fabric_busy_i,
    input logic stat_w1c,
    input logic mask_w,
    input logic stat_w,
    input logic pend_w,
    input logic msg_req_o
);

    AST_REQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n) msg_req_o |-> !mask_w); // R5
    AST_REQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) msg_req_o |-> !fabric_busy_i); // R5
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pend_w && !msg_req_o && !stat_w1c && qinv_supported_i |=> pend_w); // R6
    AST_PEND_DROP_ON_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req_o && !(cpl_valid_i && cpl_if_i) |=> !pend_w); // R6
    AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_w) |-> $past(cpl_valid_i && cpl_if_i)); // R4
    AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid_i && cpl_if_i && stat_w && !stat_w1c && !pend_w |=> !pend_w); // R4
    AST_STAT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid_i && cpl_if_i |=> stat_w); // R3
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_w1c && !(cpl_valid_i && cpl_if_i) |=> !stat_w && !pend_w); // R7
    AST_CLASH_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_w1c && cpl_valid_i && cpl_if_i && qinv_supported_i |=> stat_w && pend_w); // R8
    AST_UNSUP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !qinv_supported_i |-> !msg_req_o); // R10

endmodule

bind inv_cpl_irq_ctrl inv_cpl_irq_ctrl_chk chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .qinv_supported_i (qinv_supported_i),
    .cpl_valid_i      (cpl_valid_i),
    .cpl_if_i         (cpl_if_i),
    .fabric_busy_i    (fabric_busy_i),
    .stat_w1c         (stat_w1c),
    .mask_w           (mask_w),
    .stat_w           (stat_w),
    .pend_w           (pend_w),
    .msg_req_o        (msg_req_o)
);

// File: tb/inv_cpl_irq_ctrl_tb_top.sv
`timescale 1ns/100ps
module inv_cpl_irq_ctrl_tb_top;

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_STAT = 8'h04;
    localparam logic [7:0] A_DATA = 8'h08;
    localparam logic [7:0] A_LO   = 8'h0C;
    localparam logic [7:0] A_HI   = 8'h10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        qinv_supported_i, cpl_valid_i, cpl_if_i, fabric_busy_i;
    logic        wr_en_i, rd_en_i;
    logic [7:0]  wr_addr_i, rd_addr_i;
    logic [31:0] wr_data_i, rd_data_o, msg_data_o;
    logic        msg_req_o;
    logic [63:0] msg_addr_o;

    inv_cpl_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .qinv_supported_i(qinv_supported_i),
        .cpl_valid_i(cpl_valid_i), .cpl_if_i(cpl_if_i), .fabric_busy_i(fabric_busy_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .msg_req_o(msg_req_o), .msg_data_o(msg_data_o), .msg_addr_o(msg_addr_o)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // Drive intent and reference model state.
    logic        d_sup = 1'b1, d_cv = 1'b0, d_if = 1'b0, d_busy = 1'b0, d_wr = 1'b0, d_rd = 1'b0;
    logic [7:0]  d_waddr = '0, d_raddr = '0;
    logic [31:0] d_wdata = '0;
    logic        m_mask = 1'b1, m_pend = 1'b0, m_stat = 1'b0;
    logic [31:0] m_data = '0, m_lo = '0, m_hi = '0, exp_rd = '0;

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a, input logic sup);
        case (a)
            A_CTRL:  return sup ? {m_mask, m_pend, 30'b0} : 32'h0;
            A_STAT:  return {31'b0, m_stat};
            A_DATA:  return m_data;
            A_LO:    return m_lo;
            A_HI:    return m_hi;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [7:0] pick_addr(input int unsigned r);
        case (r % 8)
            0, 1:    return A_CTRL;
            2, 3:    return A_STAT;
            4:       return A_DATA;
            5:       return A_LO;
            6:       return A_HI;
            default: return 8'h24;
        endcase
    endfunction

    task automatic apply();
        qinv_supported_i = d_sup; cpl_valid_i = d_cv; cpl_if_i = d_if; fabric_busy_i = d_busy;
        wr_en_i = d_wr; wr_addr_i = d_waddr; wr_data_i = d_wdata;
        rd_en_i = d_rd; rd_addr_i = d_raddr;
    endtask

    // One clock: drive at the falling edge, check message outputs, advance the model at the rising edge.
    task automatic cyc();
        logic qual, clr, newc, req, n_stat, n_pend, n_mask;
        apply();
        #1;
        req = d_sup && m_pend && !m_mask && !d_busy;
        chk({63'b0, msg_req_o}, {63'b0, req}, "R5");
        chk({32'b0, msg_data_o}, {32'b0, m_data}, "R9");
        chk(msg_addr_o, {m_hi, m_lo}, "R9");
        if (d_rd) exp_rd = model_read(d_raddr, d_sup);
        qual   = d_cv && d_if;
        clr    = d_wr && d_waddr == A_STAT && d_wdata[0];
        newc   = qual && (!m_stat || clr) && d_sup;
        n_stat = qual || (m_stat && !clr);
        n_pend = !d_sup ? 1'b0 : newc ? 1'b1 : (req || clr) ? 1'b0 : m_pend;
        n_mask = (d_wr && d_waddr == A_CTRL && d_sup) ? d_wdata[31] : m_mask;
        @(posedge clk);
        #1;
        if (d_wr && d_waddr == A_DATA) m_data = d_wdata;
        if (d_wr && d_waddr == A_LO)   m_lo = d_wdata;
        if (d_wr && d_waddr == A_HI)   m_hi = d_wdata;
        m_stat = n_stat; m_pend = n_pend; m_mask = n_mask;
        chk({32'b0, rd_data_o}, {32'b0, exp_rd}, "R11");
        @(negedge clk);
        d_cv = 1'b0; d_if = 1'b0; d_wr = 1'b0; d_rd = 1'b0;
        apply();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        d_wr = 1'b1; d_waddr = a; d_wdata = v; cyc();
    endtask

    task automatic cpl(input logic iflag);
        d_cv = 1'b1; d_if = iflag; cyc();
    endtask

    task automatic rd_expect(input logic [7:0] a, input logic [31:0] v, input string tag);
        d_rd = 1'b1; d_raddr = a; cyc();
        chk({32'b0, rd_data_o}, {32'b0, v}, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic req_expect(input logic v, input string tag);
        apply();
        #0.5;
        chk({63'b0, msg_req_o}, {63'b0, v}, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd5113));
        rst_n = 1'b0;
        apply();
        repeat (3) @(negedge clk);
        chk({63'b0, msg_req_o}, 64'd0, "R1");
        chk({32'b0, rd_data_o}, 64'd0, "R1");
        rst_n = 1'b1;

        rd_expect(A_CTRL, 32'h8000_0000, "R1");
        rd_expect(A_STAT, 32'h0, "R1");

        wr(A_DATA, 32'hA5A5_1234); wr(A_LO, 32'hFEE0_0010); wr(A_HI, 32'h0000_0001);
        rd_expect(A_DATA, 32'hA5A5_1234, "R9");
        rd_expect(A_HI, 32'h0000_0001, "R9");
        chk({32'b0, msg_data_o}, {32'b0, 32'hA5A5_1234}, "R9");

        cpl(1'b0);
        rd_expect(A_STAT, 32'h0, "R3");
        cpl(1'b1);
        rd_expect(A_STAT, 32'h1, "R3");
        rd_expect(A_CTRL, 32'hC000_0000, "R6");
        idle(5);
        rd_expect(A_CTRL, 32'hC000_0000, "R6");
        req_expect(1'b0, "R5");

        wr(A_CTRL, 32'h0);
        req_expect(1'b1, "R5");
        idle(1);
        rd_expect(A_CTRL, 32'h0, "R6");
        cpl(1'b1);
        rd_expect(A_CTRL, 32'h0, "R4");
        req_expect(1'b0, "R4");

        wr(A_STAT, 32'h0);
        rd_expect(A_STAT, 32'h1, "R7");
        wr(A_STAT, 32'h1);
        rd_expect(A_STAT, 32'h0, "R7");

        d_busy = 1'b1;
        cpl(1'b1);
        idle(4);
        req_expect(1'b0, "R6");
        rd_expect(A_CTRL, 32'h4000_0000, "R6");
        d_busy = 1'b0;
        req_expect(1'b1, "R6");
        idle(1);
        rd_expect(A_CTRL, 32'h0, "R6");

        wr(A_STAT, 32'h1);
        wr(A_CTRL, 32'h8000_0000);
        cpl(1'b1);
        rd_expect(A_CTRL, 32'hC000_0000, "R7");
        wr(A_STAT, 32'h1);
        rd_expect(A_CTRL, 32'h8000_0000, "R7");
        wr(A_CTRL, 32'h0);
        req_expect(1'b0, "R7");

        cpl(1'b1);
        idle(1);
        wr(A_CTRL, 32'h8000_0000);
        d_wr = 1'b1; d_waddr = A_STAT; d_wdata = 32'h1; d_cv = 1'b1; d_if = 1'b1;
        cyc();
        rd_expect(A_STAT, 32'h1, "R8");
        rd_expect(A_CTRL, 32'hC000_0000, "R8");

        wr(A_STAT, 32'h1);
        wr(A_CTRL, 32'h7FFF_FFFF);
        rd_expect(A_CTRL, 32'h0, "R2");
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd_expect(A_CTRL, 32'h8000_0000, "R2");

        d_sup = 1'b0;
        rd_expect(A_CTRL, 32'h0, "R10");
        wr(A_CTRL, 32'h0);
        cpl(1'b1);
        req_expect(1'b0, "R10");
        d_sup = 1'b1;
        rd_expect(A_CTRL, 32'h8000_0000, "R10");
        wr(A_STAT, 32'h1);

        rd_expect(8'h40, 32'h0, "R11");
        rd_expect(8'h14, 32'h0, "R11");

        for (int i = 0; i < 4000; i++) begin
            d_cv = ($urandom % 6) == 0;
            d_if = ($urandom % 4) != 0;
            if (($urandom % 8) == 0) d_busy = !d_busy;
            if (($urandom % 60) == 0) d_sup = !d_sup;
            d_wr = ($urandom % 5) == 0;
            d_waddr = pick_addr($urandom);
            d_wdata = $urandom;
            d_rd = ($urandom % 2) == 0;
            d_raddr = pick_addr($urandom);
            cyc();
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule